// File: doc/BRIEF.md
# Multiple-register transfer sequencer

This controller carries out a load-multiple or store-multiple operation as a series of single-word memory accesses. A command is taken when `start` is high while the block is idle. The command gives a 16-entry register mask, a 32-bit base address, and four control bits: adjust before or after each transfer, increment or decrement, write back the base, and load or store. The block then presents one word access per accepted handshake on a valid/ready interface. With each access it gives the address and the number of the register that the access belongs to.

The registers are always laid out in ascending order at ascending word addresses, whichever direction is selected. In the decrement modes the block therefore starts from the bottom of the block that lies below the base. When the last access has been accepted, the block raises a one-cycle completion pulse. If write-back was requested, it reports the updated base address on the same cycle. An empty mask finishes with no accesses at all.

Top module: `mrt_seq`

## Requirements
- R1: The first access address depends on the adjust-before bit `pre_adj` and the increment bit `incr`, with n the number of set bits in `reg_list`:
  - `pre_adj`=0, `incr`=1 starts at base.
  - `pre_adj`=1, `incr`=1 starts at base+4.
  - `pre_adj`=0, `incr`=0 starts at base-4n+4.
  - `pre_adj`=1, `incr`=0 starts at base-4n.
- R2: Accesses go in ascending register number (bit i of `reg_list` is register i). Each access is at the previous address plus 4, so the lowest register always takes the lowest address.
- R3: Exactly one access completes per cycle in which `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr` and `reg_idx` hold their values.
- R4: `mem_write` is high on every access when `is_load`=0 and low on every access when `is_load`=1.
- R5: When `wb_en`=1, `wb_valid` is high during the completion cycle and `wb_addr` equals base+4n for `incr`=1 or base-4n for `incr`=0. When `wb_en`=0, `wb_valid` stays low.
- R6: `done` is a single-cycle pulse in the cycle after the last handshake. In the following cycle `busy` is low.
- R7: An empty `reg_list` produces `done` in the cycle after the command is taken, with no access. Its write-back value equals the base.
- R8: `start` and the command inputs are ignored while `busy` is high.
- R9: After reset, `busy`, `mem_valid`, `done` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Take a command when idle |
| reg_list | input | 16 | Register mask, bit i selects register i |
| base_addr | input | 32 | Base address |
| pre_adj | input | 1 | 1: adjust before each transfer, 0: after |
| incr | input | 1 | 1: increment, 0: decrement |
| wb_en | input | 1 | Report the updated base at completion |
| is_load | input | 1 | 1: load, 0: store |
| busy | output | 1 | A command is in progress |
| mem_valid | output | 1 | Access request |
| mem_ready | input | 1 | Access accepted |
| mem_write | output | 1 | Access is a store |
| mem_addr | output | 32 | Word address of the access |
| reg_idx | output | 4 | Register served by the access |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | `wb_addr` is valid |
| wb_addr | output | 32 | Updated base value |

## Verification
The hardest case to reach from the ports is a memory that stalls in the middle of a sequence while a new command is waiting at the inputs. In that case the address and index must hold, and the stray command must leave no trace. The stimulus withdraws `mem_ready` at random cycles. In one scenario it also keeps `start` high, with a different mask and base, for the whole run. The address order, the register order and the write-back value are then compared against values computed from the original command.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mrt_state_t;

    typedef struct packed {
        logic pre;
        logic up;
        logic wb;
        logic load;
    } mrt_ctl_t;

endpackage

// File: rtl/mrt_addr_gen.sv
module mrt_addr_gen #(
    parameter int NREG     = 16,
    parameter int AW       = 32,
    parameter int WB_BYTES = 4
) (
    input  logic [NREG-1:0] mask,
    input  logic [AW-1:0]   base,
    input  logic            pre,
    input  logic            up,
    output logic [AW-1:0]   first_addr,
    output logic [AW-1:0]   final_base
);
    localparam int CNTW = $clog2(NREG + 1);

    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   span;
    logic [AW-1:0]   step;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNTW'(mask[i]);
        end
    end

    assign step = AW'(WB_BYTES);
    assign span = AW'(cnt) * step;

    always_comb begin
        case ({pre, up})
            2'b01:   first_addr = base;
            2'b11:   first_addr = base + step;
            2'b00:   first_addr = base - span + step;
            default: first_addr = base - span;
        endcase
        final_base = up ? (base + span) : (base - span);
    end
endmodule

// File: rtl/mrt_list_scan.sv
module mrt_list_scan #(
    parameter int NREG = 16
) (
    input  logic [NREG-1:0]         mask,
    output logic [NREG-1:0]         pick,
    output logic [$clog2(NREG)-1:0] idx,
    output logic                    last
);
    localparam int IDXW = $clog2(NREG);

    assign pick = mask & (~mask + NREG'(1));
    assign last = ((mask & ~pick) == '0);

    genvar b;
    generate
        for (b = 0; b < IDXW; b++) begin : g_enc
            logic [NREG-1:0] sel;
            always_comb begin
                for (int i = 0; i < NREG; i++) begin
                    sel[i] = ((i >> b) & 1) != 0;
                end
            end
            assign idx[b] = |(pick & sel);
        end
    endgenerate
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
    import mrt_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int AW       = 32,
    parameter int WB_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NREG-1:0]         reg_list,
    input  logic [AW-1:0]           base_addr,
    input  logic                    pre_adj,
    input  logic                    incr,
    input  logic                    wb_en,
    input  logic                    is_load,
    output logic                    busy,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_write,
    output logic [AW-1:0]           mem_addr,
    output logic [$clog2(NREG)-1:0] reg_idx,
    output logic                    done,
    output logic                    wb_valid,
    output logic [AW-1:0]           wb_addr
);
    localparam int IDXW = $clog2(NREG);

    mrt_state_t      state;
    mrt_ctl_t        ctl_q;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wbase_q;

    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [NREG-1:0] pick;
    logic [IDXW-1:0] pick_idx;
    logic            pick_last;

    mrt_addr_gen #(.NREG(NREG), .AW(AW), .WB_BYTES(WB_BYTES)) u_addr (
        .mask       (reg_list),
        .base       (base_addr),
        .pre        (pre_adj),
        .up         (incr),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    mrt_list_scan #(.NREG(NREG)) u_scan (
        .mask (mask_q),
        .pick (pick),
        .idx  (pick_idx),
        .last (pick_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl_q   <= '0;
            mask_q  <= '0;
            addr_q  <= '0;
            wbase_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mask_q  <= reg_list;
                        addr_q  <= first_addr;
                        wbase_q <= final_base;
                        ctl_q   <= '{pre: pre_adj, up: incr, wb: wb_en, load: is_load};
                        state   <= (|reg_list) ? ST_RUN : ST_FIN;
                    end
                end
                ST_RUN: begin
                    if (mem_ready) begin
                        mask_q <= mask_q & ~pick;
                        addr_q <= addr_q + AW'(WB_BYTES);
                        if (pick_last) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign mem_valid = (state == ST_RUN);
    assign mem_write = mem_valid && !ctl_q.load;
    assign mem_addr  = addr_q;
    assign reg_idx   = pick_idx;
    assign done      = (state == ST_FIN);
    assign wb_valid  = done && ctl_q.wb;
    assign wb_addr   = wbase_q;

    // R3: a stalled access keeps its address and register
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(reg_idx)));

    // R2: the next access in a sequence is one word higher and a higher register
    a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> (!mem_valid ||
            (mem_addr == $past(mem_addr) + AW'(WB_BYTES) && reg_idx > $past(reg_idx))));

    // R6: completion lasts one cycle and the block is idle afterwards
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R7: an empty mask finishes at once without an access
    a_r7_empty_list: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && reg_list == '0) |=> (done && !mem_valid));

    // R5: the write-back report only comes with completion
    a_r5_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done);

    // R6: completion follows only a final accepted access or an empty command
    a_r6_done_source: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(mem_valid && mem_ready) || $past(start && !busy)));
endmodule

// File: tb/sim_mrt_seq.sv
module sim_mrt_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] reg_list;
    logic [31:0] base_addr;
    logic        pre_adj, incr, wb_en, is_load;
    logic        busy, mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr;
    logic [3:0]  reg_idx;
    logic        done, wb_valid;
    logic [31:0] wb_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    mrt_seq u0 (
        .clk(clk), .rst(rst), .start(start), .reg_list(reg_list),
        .base_addr(base_addr), .pre_adj(pre_adj), .incr(incr),
        .wb_en(wb_en), .is_load(is_load), .busy(busy),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .reg_idx(reg_idx), .done(done),
        .wb_valid(wb_valid), .wb_addr(wb_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            report();
        end
    end

    // Runs one command and checks every access, completion and write-back.
    // stall: 1 = random mem_ready; noise: keep start high with a foreign command
    task automatic run_cmd(input logic [15:0] lst, input logic [31:0] base,
                           input bit p, input bit u, input bit w, input bit l,
                           input bit stall, input bit noise);
        int          n = 0;
        int          k = 0;
        int          next_reg = 0;
        int          iter = 0;
        bit          seen_done = 0;
        logic [31:0] exp_first, exp_wb, prev_addr;
        logic [3:0]  prev_idx;
        bit          prev_stall = 0;
        for (int i = 0; i < 16; i++) if (lst[i]) n++;
        if (u) exp_first = p ? base + 32'd4 : base;
        else   exp_first = p ? base - 32'(4 * n) : base - 32'(4 * n) + 32'd4;
        exp_wb = u ? base + 32'(4 * n) : base - 32'(4 * n);
        @(negedge clk);
        start = 1'b1; reg_list = lst; base_addr = base;
        pre_adj = p; incr = u; wb_en = w; is_load = l;
        mem_ready = 1'b0;
        @(negedge clk);
        if (noise) begin
            reg_list = ~lst; base_addr = base ^ 32'h00F0_0000;
            pre_adj = ~p; incr = ~u; wb_en = ~w; is_load = ~l;
        end else begin
            start = 1'b0;
        end
        while (!seen_done && iter < 200) begin
            mem_ready = stall ? 1'($urandom % 2) : 1'b1;
            #1;
            if (done) begin
                seen_done = 1;
                start = 1'b0;
            end else if (mem_valid) begin
                if (prev_stall) begin
                    check(mem_addr == prev_addr, "R3 addr held", mem_addr, prev_addr);
                    check(reg_idx == prev_idx, "R3 idx held", 32'(reg_idx), 32'(prev_idx));
                end
                while (next_reg < 16 && !lst[next_reg]) next_reg++;
                check(32'(reg_idx) == 32'(next_reg), "R2 register order",
                      32'(reg_idx), 32'(next_reg));
                if (k == 0)
                    check(mem_addr == exp_first, "R1 first address", mem_addr, exp_first);
                else
                    check(mem_addr == exp_first + 32'(4 * k), "R2 address step",
                          mem_addr, exp_first + 32'(4 * k));
                check(mem_write == !l, "R4 direction", 32'(mem_write), 32'(!l));
                prev_addr = mem_addr; prev_idx = reg_idx;
                prev_stall = !mem_ready;
                if (mem_ready) begin
                    k++;
                    next_reg++;
                end
            end
            if (!seen_done) @(negedge clk);
            iter++;
        end
        check(seen_done, "R6 done seen", 32'(seen_done), 32'd1);
        check(k == n, "R3 access count", 32'(k), 32'(n));
        check(wb_valid == w, "R5 wb_valid", 32'(wb_valid), 32'(w));
        if (w) check(wb_addr == exp_wb, "R5 wb_addr", wb_addr, exp_wb);
        @(negedge clk);
        mem_ready = 1'b0;
        #1;
        check(!done && !busy, "R6 single pulse then idle", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; mem_ready = 1'b0;
        reg_list = '0; base_addr = '0;
        pre_adj = 0; incr = 0; wb_en = 0; is_load = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!busy && !mem_valid && !done && !wb_valid, "R9 reset state",
              {28'd0, busy, mem_valid, done, wb_valid}, 32'd0);
    endtask

    task automatic t_all_modes;
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 3; r++) begin
                logic [15:0] lst = 16'($urandom) | 16'h0001;
                run_cmd(lst, 32'h0010_0000 + 32'($urandom % 256) * 4,
                        m[1], m[0], 1'b1, m[2], 1'b0, 1'b0);
            end
        end
    endtask

    task automatic t_stall;
        run_cmd(16'hA5C3, 32'h0000_8000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_cmd(16'h8001, 32'h0000_0100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_empty;   // R7
        run_cmd(16'h0000, 32'h0000_4000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_cmd(16'h0000, 32'h0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_full_and_single;
        run_cmd(16'hFFFF, 32'h0000_0040, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_cmd(16'h8000, 32'h0000_0200, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_no_writeback;   // R5 with write-back off
        run_cmd(16'h0F0F, 32'h0000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_busy_ignore;   // R8: foreign command held on the inputs
        run_cmd(16'h1234, 32'h0002_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        run_cmd(16'h00F1, 32'h0002_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_all_modes();
        t_stall();
        t_empty();
        t_full_and_single();
        t_no_writeback();
        t_busy_ignore();
        report();
    end
endmodule